// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This unit turns an instruction fetch address into a physical address and decides whether the fetch may go ahead. A lookup structure outside the block supplies the candidate translation entry for the fetch. The entry carries a hit flag, an address-space tag, a global flag, a physical page number and a four-bit per-mode read-enable mask. The unit combines that entry with the current privilege mode, the current address-space number and a physical-mode flag. It registers the resulting physical address and a two-bit fault code one cycle after the request.

The unit checks the fetch address in a fixed priority order. A fetch address with its least significant bit set is privileged code and bypasses translation. With the physical-mode flag set, the address passes through untranslated. Otherwise the address must be a sign-extended 48-bit virtual address. A fixed window of that space maps straight to physical memory, and only kernel mode may use it. Every other address goes through the external entry. When a fault is raised, two fault registers record the fetch address and a page-table-formatted address, which a miss handler can use at once. A squash input stops a fetch on a wrong path from overwriting those registers.

Top module: `itrans_unit`

## Requirements
- R1: After a synchronous active-low reset, out_valid, out_pa, out_fault, fault_tag and fault_form are all zero.
- R2: A request whose pc bit 0 is 1 yields out_pa = pc[43:0] with bits 1:0 cleared and fault 0 (none). This holds whatever the mode, the physical-mode flag and the entry inputs are.
- R3: With pc bit 0 clear and phys_mode set, out_pa = pc[43:0]. If pc[63:44] is zero, the fault is 0 (none).
- R4: With pc bit 0 clear and phys_mode set, any set bit in pc[63:44] gives fault 3 (machine check).
- R5: With pc bit 0 clear and phys_mode clear, pc[63:47] must be all zeros or all ones. Otherwise the fault is 1 (access violation).
- R6: A valid address with pc[47:41] = 7'h7e is a superpage fetch. In kernel mode (cur_mode 0) it gives fault 0, and out_pa[39:0] = pc[39:0] with out_pa[43:40] equal to four copies of pc[40].
- R7: A superpage fetch in any mode other than kernel (1 executive, 2 supervisor, 3 user) gives fault 1.
- R8: For any other valid address, the entry matches only if tlb_hit is 1 and either tlb_global is 1 or tlb_asn equals cur_asn. No match gives fault 2 (miss).
- R9: On a match, out_pa = (tlb_ppn << 13) + (pc[12:0] with bits 1:0 cleared). A global entry matches whatever the address-space numbers are.
- R10: On a match, if tlb_rd_en[cur_mode] is 0, the fault is 1 (access violation).
- R11: When a request faults and squash is low, at the next edge fault_tag takes pc. At the same edge fault_form takes pt_base OR (pc[47:13] << 3).
- R12: When squash is high with a request, fault_tag and fault_form keep their values, while out_pa and out_fault still update.
- R13: out_valid is 1 exactly one cycle after a cycle with req_valid high. A cycle without a request leaves fault_tag and fault_form unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Fetch request this cycle |
| pc | input | 64 | Fetch address |
| phys_mode | input | 1 | Treat the fetch address as physical |
| cur_mode | input | 2 | Privilege mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| cur_asn | input | 8 | Current address-space number |
| tlb_hit | input | 1 | External lookup found an entry for the page |
| tlb_asn | input | 8 | Address-space number of the entry |
| tlb_global | input | 1 | Entry matches every address space |
| tlb_ppn | input | 31 | Physical page number of the entry |
| tlb_rd_en | input | 4 | Per-mode read enable, indexed by cur_mode |
| pt_base | input | 64 | Page-table base used for the formatted fault address |
| squash | input | 1 | Fetch on a wrong path: do not record faults |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| out_pa | output | 44 | Physical address |
| out_fault | output | 2 | 0 none, 1 access violation, 2 miss, 3 machine check |
| fault_tag | output | 64 | Fetch address of the last recorded fault |
| fault_form | output | 64 | Formatted page-table address of the last recorded fault |

## Verification
The bench targets the priority of the checks. An odd pc that also carries physical mode, a user mode or a bad sign extension must still bypass, so a design that ordered the checks wrongly would report a fault. The bench covers both values of bit 40 in the superpage window, which catches a design that truncates or sign-extends only one way. It sends global entries whose address-space numbers differ, which a design that ignores the global flag would report as misses. It also sends squashed faults and idle cycles; a design that gates the fault registers loosely would overwrite the recorded tag with the wrong-path or idle address.

// File: rtl/itrans_pkg.sv
// Shared encodings for the instruction fetch translator.
// Assumes a two-bit fault code and a two-bit privilege mode.
package itrans_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_ACV  = 2'd1,
        FLT_MISS = 2'd2,
        FLT_MCHK = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        MODE_KERN = 2'd0,
        MODE_EXEC = 2'd1,
        MODE_SUPV = 2'd2,
        MODE_USER = 2'd3
    } mode_e;
endpackage

// File: rtl/itrans_va_class.sv
// Classifies a fetch address: is it a sign-extended virtual address,
// and does it fall in the direct-mapped superpage window.
// Assumes PC_W > VA_BITS > SP_LO.
module itrans_va_class #(
    parameter int PC_W     = 64,
    parameter int VA_BITS  = 48,
    parameter int SP_LO    = 41,
    parameter int SP_TAG   = 'h7e
) (
    input  logic [PC_W-1:0] pc,
    output logic            va_ok,
    output logic            is_super
);
    localparam int EXT_W = PC_W - VA_BITS + 1;
    localparam int TAG_W = VA_BITS - SP_LO;

    logic [EXT_W-1:0] ext_bits;
    logic [TAG_W-1:0] win_bits;

    // Sign-extension test and window decode.
    always_comb begin
        ext_bits = pc[PC_W-1:VA_BITS-1];
        win_bits = pc[VA_BITS-1:SP_LO];
        va_ok    = (&ext_bits) | ~(|ext_bits);
        is_super = (win_bits == TAG_W'(SP_TAG));
    end
endmodule

// File: rtl/itrans_super_map.sv
// Direct physical mapping for the superpage window: the bits at and
// above SIGN_BIT are replaced by copies of the SIGN_BIT bit.
// Assumes SIGN_BIT < PA_BITS.
module itrans_super_map #(
    parameter int PA_BITS  = 44,
    parameter int SIGN_BIT = 40
) (
    input  logic [PA_BITS-1:0] pa_raw,
    output logic [PA_BITS-1:0] pa
);
    localparam int HI_W = PA_BITS - SIGN_BIT;

    // Replicate the sign bit across the upper field.
    always_comb begin
        pa = {{HI_W{pa_raw[SIGN_BIT]}}, pa_raw[SIGN_BIT-1:0]};
    end
endmodule

// File: rtl/itrans_tlb_path.sv
// Qualifies the external lookup result and forms the mapped address.
// Assumes the lookup structure already compared the page number; this
// unit only adds the address-space match and the per-mode permission.
module itrans_tlb_path #(
    parameter int PA_BITS    = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int ASN_W      = 8,
    parameter int N_MODES    = 4
) (
    input  logic [PAGE_SHIFT-1:2]         offs,
    input  logic [$clog2(N_MODES)-1:0]    mode,
    input  logic [ASN_W-1:0]              asn,
    input  logic                          hit,
    input  logic [ASN_W-1:0]              ent_asn,
    input  logic                          ent_global,
    input  logic [PA_BITS-PAGE_SHIFT-1:0] ent_ppn,
    input  logic [N_MODES-1:0]            ent_rd_en,
    output logic                          match,
    output logic                          perm_ok,
    output logic [PA_BITS-1:0]            pa
);
    // Address-space match, mode permission and address concatenation.
    always_comb begin
        match   = hit & (ent_global | (ent_asn == asn));
        perm_ok = ent_rd_en[mode];
        pa      = {ent_ppn, offs, 2'b00};
    end
endmodule

// File: rtl/itrans_fault_regs.sv
// Holds the fault-tag and formatted-fault-address registers.
// Assumes capture already folds in request, fault and squash.
module itrans_fault_regs #(
    parameter int PC_W       = 64,
    parameter int VA_BITS    = 48,
    parameter int PAGE_SHIFT = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] pt_base,
    output logic [PC_W-1:0] tag_q,
    output logic [PC_W-1:0] form_q
);
    localparam int VPN_W = VA_BITS - PAGE_SHIFT;

    logic [PC_W-1:0] form_n;

    // Page-table entry address: base OR page number times eight.
    always_comb begin
        form_n = pt_base | (PC_W'(pc[VA_BITS-1:PAGE_SHIFT]) << 3);
    end

    // Record on capture only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q  <= '0;
            form_q <= '0;
        end else if (capture) begin
            tag_q  <= pc;
            form_q <= form_n;
        end
    end

    logic [VPN_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/itrans_unit.sv
// Instruction fetch translator top. Evaluates the fetch address in a
// fixed priority (privileged bypass, physical mode, validity,
// superpage, mapped entry) and registers the address and fault code.
// Assumes the external lookup result is presented with the request.
module itrans_unit #(
    parameter int PC_W       = 64,
    parameter int VA_BITS    = 48,
    parameter int PA_BITS    = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int ASN_W      = 8,
    parameter int SP_LO      = 41,
    parameter int SP_TAG     = 'h7e,
    parameter int SIGN_BIT   = 40
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [PC_W-1:0]               pc,
    input  logic                          phys_mode,
    input  logic [1:0]                    cur_mode,
    input  logic [ASN_W-1:0]              cur_asn,
    input  logic                          tlb_hit,
    input  logic [ASN_W-1:0]              tlb_asn,
    input  logic                          tlb_global,
    input  logic [PA_BITS-PAGE_SHIFT-1:0] tlb_ppn,
    input  logic [3:0]                    tlb_rd_en,
    input  logic [PC_W-1:0]               pt_base,
    input  logic                          squash,
    output logic                          out_valid,
    output logic [PA_BITS-1:0]            out_pa,
    output logic [1:0]                    out_fault,
    output logic [PC_W-1:0]               fault_tag,
    output logic [PC_W-1:0]               fault_form
);
    import itrans_pkg::*;

    logic               va_ok, is_super, ent_match, ent_perm;
    logic [PA_BITS-1:0] sp_pa, ent_pa, pa_n;
    flt_e               flt_n;
    logic               cap;

    itrans_va_class #(
        .PC_W(PC_W), .VA_BITS(VA_BITS), .SP_LO(SP_LO), .SP_TAG(SP_TAG)
    ) cls_i (
        .pc(pc), .va_ok(va_ok), .is_super(is_super)
    );

    itrans_super_map #(
        .PA_BITS(PA_BITS), .SIGN_BIT(SIGN_BIT)
    ) spm_i (
        .pa_raw(pc[PA_BITS-1:0]), .pa(sp_pa)
    );

    itrans_tlb_path #(
        .PA_BITS(PA_BITS), .PAGE_SHIFT(PAGE_SHIFT), .ASN_W(ASN_W), .N_MODES(4)
    ) tlp_i (
        .offs(pc[PAGE_SHIFT-1:2]), .mode(cur_mode), .asn(cur_asn),
        .hit(tlb_hit), .ent_asn(tlb_asn), .ent_global(tlb_global),
        .ent_ppn(tlb_ppn), .ent_rd_en(tlb_rd_en),
        .match(ent_match), .perm_ok(ent_perm), .pa(ent_pa)
    );

    // Priority decision of address and fault.
    always_comb begin
        pa_n  = '0;
        flt_n = FLT_NONE;
        if (pc[0]) begin
            pa_n = {pc[PA_BITS-1:2], 2'b00};
        end else if (phys_mode) begin
            pa_n = pc[PA_BITS-1:0];
            if (|pc[PC_W-1:PA_BITS]) flt_n = FLT_MCHK;
        end else if (!va_ok) begin
            flt_n = FLT_ACV;
        end else if (is_super) begin
            if (mode_e'(cur_mode) != MODE_KERN) flt_n = FLT_ACV;
            else                                pa_n  = sp_pa;
        end else if (!ent_match) begin
            flt_n = FLT_MISS;
        end else begin
            pa_n = ent_pa;
            if (!ent_perm) flt_n = FLT_ACV;
        end
    end

    // Fault registers record only real, non-squashed faults.
    always_comb begin
        cap = req_valid & (flt_n != FLT_NONE) & ~squash;
    end

    itrans_fault_regs #(
        .PC_W(PC_W), .VA_BITS(VA_BITS), .PAGE_SHIFT(PAGE_SHIFT)
    ) frg_i (
        .clk(clk), .rst_n(rst_n), .capture(cap), .pc(pc),
        .pt_base(pt_base), .tag_q(fault_tag), .form_q(fault_form)
    );

    // Result register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pa    <= '0;
            out_fault <= FLT_NONE;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_pa    <= pa_n;
                out_fault <= flt_n;
            end
        end
    end
endmodule

// File: rtl/itrans_unit_chk.sv
// Temporal checks on the translator ports, bound to every instance.
module itrans_unit_chk #(
    parameter int PC_W    = 64,
    parameter int VA_BITS = 48,
    parameter int PA_BITS = 44
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [PC_W-1:0]    pc,
    input logic               phys_mode,
    input logic [1:0]         cur_mode,
    input logic               tlb_hit,
    input logic               squash,
    input logic               out_valid,
    input logic [PA_BITS-1:0] out_pa,
    input logic [1:0]         out_fault,
    input logic [PC_W-1:0]    fault_tag,
    input logic [PC_W-1:0]    fault_form
);
    logic       sext_ok, in_win, plain;
    assign sext_ok = (pc[PC_W-1:VA_BITS-1] == '0) || (pc[PC_W-1:VA_BITS-1] == '1);
    assign in_win  = (pc[VA_BITS-1:VA_BITS-7] == 7'h7e);
    assign plain   = req_valid && !pc[0] && !phys_mode;

    a_r2_bypass_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && pc[0] |=> out_valid && out_fault == 2'd0
            && out_pa == {$past(pc[PA_BITS-1:2]), 2'b00});

    a_r4_phys_mcheck: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !pc[0] && phys_mode && (|pc[PC_W-1:PA_BITS]) |=> out_fault == 2'd3);

    a_r5_bad_sext_acv: assert property (@(posedge clk) disable iff (!rst_n)
        plain && !sext_ok |=> out_fault == 2'd1);

    a_r7_super_nonkernel_acv: assert property (@(posedge clk) disable iff (!rst_n)
        plain && sext_ok && in_win && cur_mode != 2'd0 |=> out_fault == 2'd1);

    a_r8_no_hit_miss: assert property (@(posedge clk) disable iff (!rst_n)
        plain && sext_ok && !in_win && !tlb_hit |=> out_fault == 2'd2);

    a_r11_tag_follows_fault: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !squash ##1 out_fault != 2'd0 |-> fault_tag == $past(pc));

    a_r12_squash_holds: assert property (@(posedge clk) disable iff (!rst_n)
        squash |=> $stable(fault_tag) && $stable(fault_form));

    a_r13_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid && $stable(fault_tag) && $stable(fault_form));
endmodule

bind itrans_unit itrans_unit_chk #(
    .PC_W(PC_W), .VA_BITS(VA_BITS), .PA_BITS(PA_BITS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc(pc),
    .phys_mode(phys_mode), .cur_mode(cur_mode), .tlb_hit(tlb_hit),
    .squash(squash), .out_valid(out_valid), .out_pa(out_pa),
    .out_fault(out_fault), .fault_tag(fault_tag), .fault_form(fault_form)
);

// File: tb/itrans_unit_tb_top.sv
module itrans_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] pc = '0;
    logic        phys_mode = 1'b0;
    logic [1:0]  cur_mode = '0;
    logic [7:0]  cur_asn = '0;
    logic        tlb_hit = 1'b0;
    logic [7:0]  tlb_asn = '0;
    logic        tlb_global = 1'b0;
    logic [30:0] tlb_ppn = '0;
    logic [3:0]  tlb_rd_en = '0;
    logic [63:0] pt_base = '0;
    logic        squash = 1'b0;
    logic        out_valid;
    logic [43:0] out_pa;
    logic [1:0]  out_fault;
    logic [63:0] fault_tag, fault_form;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] exp_tag = '0, exp_form = '0;

    always #10 clk = ~clk;

    itrans_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc(pc),
        .phys_mode(phys_mode), .cur_mode(cur_mode), .cur_asn(cur_asn),
        .tlb_hit(tlb_hit), .tlb_asn(tlb_asn), .tlb_global(tlb_global),
        .tlb_ppn(tlb_ppn), .tlb_rd_en(tlb_rd_en), .pt_base(pt_base),
        .squash(squash), .out_valid(out_valid), .out_pa(out_pa),
        .out_fault(out_fault), .fault_tag(fault_tag), .fault_form(fault_form)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected result from the requirements.
    function automatic void model(output logic [43:0] epa, output logic [1:0] ef, output string rq);
        epa = '0; ef = 2'd0; rq = "R9";
        if (pc[0]) begin
            epa = pc[43:0] & ~44'h3; rq = "R2";
        end else if (phys_mode) begin
            epa = pc[43:0]; rq = "R3";
            if (pc[63:44] != 0) begin ef = 2'd3; rq = "R4"; end
        end else if (!(pc[63:47] == 17'h0 || pc[63:47] == 17'h1ffff)) begin
            ef = 2'd1; rq = "R5";
        end else if (pc[47:41] == 7'h7e) begin
            if (cur_mode != 2'd0) begin ef = 2'd1; rq = "R7"; end
            else begin
                rq = "R6";
                epa = pc[43:0];
                epa[43:40] = pc[40] ? 4'hf : 4'h0;
            end
        end else if (!(tlb_hit && (tlb_global || tlb_asn == cur_asn))) begin
            ef = 2'd2; rq = "R8";
        end else begin
            epa = {tlb_ppn, 13'h0} + {31'h0, pc[12:0] & 13'h1ffc};
            if (!tlb_rd_en[cur_mode]) begin ef = 2'd1; rq = "R10"; end
        end
    endfunction

    // Inputs are already set at a falling edge; result checked one cycle later.
    task automatic fire();
        logic [43:0] epa; logic [1:0] ef; string rq;
        model(epa, ef, rq);
        req_valid = 1'b1;
        if (ef != 2'd0 && !squash) begin
            exp_tag  = pc;
            exp_form = pt_base | ({29'h0, pc[47:13]} << 3);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R13 valid", {63'h0, out_valid}, 64'h1);
        check(out_fault == ef, rq, {62'h0, out_fault}, {62'h0, ef});
        if (ef == 2'd0 || ef == 2'd3)
            check(out_pa == epa, rq, {20'h0, out_pa}, {20'h0, epa});
        check(fault_tag == exp_tag, squash ? "R12 tag" : "R11 tag", fault_tag, exp_tag);
        check(fault_form == exp_form, squash ? "R12 form" : "R11 form", fault_form, exp_form);
        squash = 1'b0;
    endtask

    task automatic set_tlb_pc(input logic [34:0] vpn, input logic [12:0] off);
        pc = {{17{vpn[34]}}, vpn[34:0], off} & ~64'h1;
    endtask

    initial begin
        #4_000_000;
        n_fail++; n_tests++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid == 0 && out_pa == 0 && out_fault == 0, "R1 outputs", {out_pa, 1'b0, out_valid, out_fault}, 64'h0);
        check(fault_tag == 0 && fault_form == 0, "R1 fault regs", fault_tag | fault_form, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        pt_base = 64'h0000_0200_0000_0000;

        // R2 bypass wins over physical mode, user mode and bad sign extension
        pc = 64'h8000_0123_4567_89ab; phys_mode = 1; cur_mode = 3; fire();
        // R3 physical with clean upper bits
        pc = 64'h0000_0abc_def0_1234; phys_mode = 1; fire();
        // R4 physical with upper bits set
        pc = 64'h0010_0000_0000_1000; fire();
        phys_mode = 0;
        // R5 bad sign extension
        pc = 64'h0001_0000_0000_0000; fire();
        // R6 superpage kernel, bit 40 high and low
        cur_mode = 0; pc = 64'hffff_fd12_3456_7890; fire();
        pc = 64'hffff_fc12_3456_7890; fire();
        // R7 superpage in supervisor mode
        cur_mode = 2; fire();
        // R8 asn mismatch, not global
        cur_mode = 1; set_tlb_pc(35'h12345, 13'h0abc);
        tlb_hit = 1; tlb_asn = 8'h11; cur_asn = 8'h22; tlb_global = 0;
        tlb_ppn = 31'h1234567; tlb_rd_en = 4'b0010; fire();
        // R9 global entry with mismatched asn hits
        tlb_global = 1; fire();
        // R10 permission missing for current mode
        cur_mode = 3; fire();
        // R12 squashed fault keeps the recorded registers
        squash = 1; tlb_hit = 0; set_tlb_pc(35'h7_0000_0001, 13'h0010); fire();
        // R13 idle cycle with a faulting address
        req_valid = 0; pc = 64'h0001_0000_0000_0000;
        @(negedge clk);
        check(out_valid == 0, "R13 idle valid", {63'h0, out_valid}, 64'h0);
        check(fault_tag == exp_tag, "R13 idle tag", fault_tag, exp_tag);
        check(fault_form == exp_form, "R13 idle form", fault_form, exp_form);

        // Random mix over all paths
        for (int i = 0; i < 600; i++) begin
            int cat;
            cat = $urandom_range(0, 5);
            pc = {$urandom, $urandom};
            phys_mode = 0;
            cur_mode = 2'($urandom_range(0, 3));
            cur_asn = 8'($urandom_range(0, 3));
            tlb_asn = 8'($urandom_range(0, 3));
            tlb_global = ($urandom_range(0, 3) == 0);
            tlb_hit = ($urandom_range(0, 3) != 0);
            tlb_ppn = 31'($urandom);
            tlb_rd_en = 4'($urandom);
            pt_base = {$urandom, $urandom} & 64'hffff_ffff_ffff_0000;
            squash = ($urandom_range(0, 7) == 0);
            case (cat)
                0: pc[0] = 1'b1;
                1: begin
                    phys_mode = 1; pc[0] = 1'b0;
                    if ($urandom_range(0, 1) == 1) pc[63:44] = '0;
                end
                2: pc[0] = 1'b0;
                3: begin
                    pc[63:41] = {16'hffff, 7'h7e}; pc[0] = 1'b0;
                    if ($urandom_range(0, 1) == 1) cur_mode = 2'd0;
                end
                default: begin
                    set_tlb_pc(35'($urandom), 13'($urandom));
                    if (pc[47:41] == 7'h7e) pc[41] = 1'b1;
                end
            endcase
            fire();
        end

        req_valid = 0;
        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule